// File: doc/BRIEF.md
# Sinc3 Decimation Filter with Selectable Ratio

This block converts a single-bit oversampled modulator stream into signed 16-bit PCM words. The filter is a third-order cascaded integrator-comb structure with a sinc-cubed response. The three integrators run at the modulator rate, and the three comb stages, each with a differential delay of one, run at the output rate. A 2-bit code picks the decimation ratio while the block is running. One modulator clock therefore serves four output rates. With 2.048 MHz input samples these are 64, 32, 16 and 8 kHz.

All filter arithmetic is two's complement with wrap-around. The accumulators carry the full word growth of the largest ratio, so the comb outputs are always exact. A right shift that depends on the ratio brings every ratio to the same output gain, and saturation keeps full scale within 16 bits. The filter adds no passband droop correction; any sharper filtering belongs downstream. The group delay is 3·(M−1)/2 input intervals.

Top module: `sinc3_decim`

## Requirements
- R1: Input bit 1 counts as +1 and bit 0 as −1. For an input pattern that repeats every 8 enables with a fraction p of ones, every valid output equals round-free 32768·(2p−1), limited as in R5.
- R2: The rate select code picks the decimation ratio: 0 gives 32, 1 gives 64, 2 gives 128 and 3 gives 256.
- R3: The valid output is high for exactly one clock cycle. It rises in the clock after the enable that completes a group of M accepted enables, and consecutive strobes are M enables apart.
- R4: After a clear or a reset, the first valid strobe follows the 3·M-th accepted enable, because the comb delays must first refill over three output periods.
- R5: The output saturates. A steady all-ones input gives +32767 and a steady all-zeros input gives −32768 at every ratio.
- R6: While the enable is low, the bitstream input is ignored. The output word holds its value and no strobe is produced.
- R7: A change of the rate select code clears the decimation counter and all integrator and comb state. An enable in the same cycle as the change is discarded.
- R8: An asynchronous active-low reset sets the output word to 0 and valid to 0, selects code 0 and clears all filter state.
- R9: The output is the final comb value shifted right arithmetically by 3·code bits. This gives the same scale for every ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_en | input | 1 | Modulator-rate sample enable |
| mod_bit | input | 1 | Single-bit modulator stream |
| rate_sel | input | 2 | Decimation ratio code |
| pcm_out | output | 16 | Signed decimated sample |
| pcm_valid | output | 1 | One-cycle strobe for a new sample |

## Verification
Each table vector changes the ratio before it runs. The bench counts the enables up to the first strobe, so a design that refilled the combs too early or too late gives a first-strobe position other than 3·M. The bench also drives the inverted bit during every idle cycle. A design that integrated while the enable was low would then produce the wrong DC level on every vector. Full-scale inputs at every ratio expose a missing saturation or a wrong shift, which shows up as a wrapped sign or a gain off by powers of eight. A reset in the middle of a run must zero the outputs and restart the refill count.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

   // Number of integrator/comb pairs fixed by the sinc-cubed response
   localparam int FILTER_ORDER = 3;

   // Ratio codes
   typedef enum logic [1:0] {
      RATE_X32  = 2'd0,
      RATE_X64  = 2'd1,
      RATE_X128 = 2'd2,
      RATE_X256 = 2'd3
   } rate_code_e;

   // Bits of word growth for a given log2 ratio
   function automatic int growth_bits(input int order, input int log2_ratio);
      return order * log2_ratio;
   endfunction

endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl #(
   parameter int MIN_LOG2 = 5,
   parameter int N_RATES  = 4,
   parameter int ORDER    = 3,
   parameter int SEL_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] rate_sel,
   output logic             clr,
   output logic             tick,
   output logic             fill_ok,
   output logic [SEL_W-1:0] rate_q
);
   localparam int CNT_W  = MIN_LOG2 + N_RATES - 1;
   localparam int FILL_W = (ORDER > 2) ? $clog2(ORDER) : 1;

   if (N_RATES > (1 << SEL_W)) begin : g_bad_sel
      $error("rate select too narrow for N_RATES");
   end
   if (ORDER < 2) begin : g_bad_order
      $error("ORDER must be at least 2");
   end

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W:0]    ratio;
   logic [CNT_W-1:0]  last_cnt;
   logic [FILL_W-1:0] fill;

   assign ratio    = (CNT_W+1)'(1) << (MIN_LOG2 + int'(rate_q));
   assign last_cnt = CNT_W'(ratio - 1'b1);
   assign clr      = (rate_sel != rate_q);
   assign tick     = en && !clr && (cnt == last_cnt);
   assign fill_ok  = (fill == FILL_W'(ORDER - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= '0;
         cnt    <= '0;
         fill   <= '0;
      end else if (clr) begin
         rate_q <= rate_sel;
         cnt    <= '0;
         fill   <= '0;
      end else if (en) begin
         cnt <= tick ? '0 : cnt + 1'b1;
         if (tick && !fill_ok)
            fill <= fill + 1'b1;
      end
   end

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= last_cnt);

   // R7
   clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0) && (fill == '0));

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
   parameter int ACC_W = 26,
   parameter int ORDER = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    clr,
   input  logic                    bit_i,
   output logic signed [ACC_W-1:0] last_next
);
   logic signed [ACC_W-1:0] acc [ORDER];
   logic signed [ACC_W-1:0] nxt [ORDER];
   logic signed [ACC_W-1:0] x_in;

   // +1 for a one, -1 (all ones) for a zero
   assign x_in = bit_i ? ACC_W'(1) : '1;

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      if (k == 0) begin : g_first
         assign nxt[k] = acc[k] + x_in;
      end else begin : g_rest
         assign nxt[k] = acc[k] + acc[k-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            acc[k] <= '0;
         else if (clr)
            acc[k] <= '0;
         else if (en)
            acc[k] <= nxt[k];
      end

      // R6
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!en && !clr) |=> $stable(acc[k]));
   end

   assign last_next = nxt[ORDER-1];

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
   parameter int ACC_W    = 26,
   parameter int ORDER    = 3,
   parameter int OUT_W    = 16,
   parameter int MIN_LOG2 = 5,
   parameter int SEL_W    = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    tick,
   input  logic                    fill_ok,
   input  logic [SEL_W-1:0]        rate_q,
   input  logic signed [ACC_W-1:0] din,
   output logic signed [OUT_W-1:0] sample,
   output logic                    valid
);
   localparam int BASE_SH = ORDER * MIN_LOG2 - (OUT_W - 1);
   localparam logic signed [ACC_W-1:0] SAT_HI =
      {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] SAT_LO =
      {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   if (BASE_SH < 0) begin : g_bad_shift
      $error("smallest ratio gives less growth than the output width");
   end
   if (ACC_W <= OUT_W) begin : g_bad_width
      $error("accumulator must be wider than the output");
   end

   logic signed [ACC_W-1:0] dly  [ORDER];
   logic signed [ACC_W-1:0] diff [ORDER];
   logic signed [ACC_W-1:0] scaled;
   logic signed [ACC_W-1:0] limited;
   int                      sh;

   for (genvar k = 0; k < ORDER; k++) begin : g_comb
      if (k == 0) begin : g_first
         assign diff[k] = din - dly[k];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       dly[k] <= '0;
            else if (clr)     dly[k] <= '0;
            else if (tick)    dly[k] <= din;
         end
      end else begin : g_rest
         assign diff[k] = diff[k-1] - dly[k];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       dly[k] <= '0;
            else if (clr)     dly[k] <= '0;
            else if (tick)    dly[k] <= diff[k-1];
         end
      end
   end

   always_comb begin
      sh     = BASE_SH + ORDER * int'(rate_q);
      scaled = diff[ORDER-1] >>> sh;
      if (scaled > SAT_HI)
         limited = SAT_HI;
      else if (scaled < SAT_LO)
         limited = SAT_LO;
      else
         limited = scaled;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample <= '0;
         valid  <= 1'b0;
      end else if (clr) begin
         sample <= '0;
         valid  <= 1'b0;
      end else begin
         valid <= tick && fill_ok;
         if (tick)
            sample <= limited[OUT_W-1:0];
      end
   end

   // R3
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R6
   sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(sample));

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
   import sinc3_pkg::*;
#(
   parameter int OUT_W    = 16,
   parameter int MIN_LOG2 = 5,
   parameter int N_RATES  = 4,
   parameter int SEL_W    = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mod_en,
   input  logic                    mod_bit,
   input  logic [SEL_W-1:0]        rate_sel,
   output logic signed [OUT_W-1:0] pcm_out,
   output logic                    pcm_valid
);
   localparam int ORDER    = FILTER_ORDER;
   localparam int MAX_LOG2 = MIN_LOG2 + N_RATES - 1;
   localparam int ACC_W    = 2 + growth_bits(ORDER, MAX_LOG2);

   logic                    clr;
   logic                    tick;
   logic                    fill_ok;
   logic [SEL_W-1:0]        rate_q;
   logic signed [ACC_W-1:0] integ_last;

   sinc3_ctrl #(
      .MIN_LOG2 (MIN_LOG2),
      .N_RATES  (N_RATES),
      .ORDER    (ORDER),
      .SEL_W    (SEL_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (mod_en),
      .rate_sel (rate_sel),
      .clr      (clr),
      .tick     (tick),
      .fill_ok  (fill_ok),
      .rate_q   (rate_q)
   );

   sinc3_integ #(
      .ACC_W (ACC_W),
      .ORDER (ORDER)
   ) u_integ (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (mod_en),
      .clr       (clr),
      .bit_i     (mod_bit),
      .last_next (integ_last)
   );

   sinc3_comb #(
      .ACC_W    (ACC_W),
      .ORDER    (ORDER),
      .OUT_W    (OUT_W),
      .MIN_LOG2 (MIN_LOG2),
      .SEL_W    (SEL_W)
   ) u_comb (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .tick    (tick),
      .fill_ok (fill_ok),
      .rate_q  (rate_q),
      .din     (integ_last),
      .sample  (pcm_out),
      .valid   (pcm_valid)
   );

   // R3
   valid_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_valid |-> $past(mod_en));

   // R7
   change_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel != $past(rate_sel)) |=> !pcm_valid);

endmodule

// File: tb/sim_sinc3_decim.sv
module sim_sinc3_decim;

   typedef struct packed {
      logic [1:0]         rate;
      logic [7:0]         pat;
      logic signed [31:0] exp;
   } vec_t;

   // pattern bit i (LSB first) is fed at enable i mod 8
   localparam vec_t VECS [8] = '{
      '{2'd0, 8'hFF,  32'sd32767},   // R5 full scale up
      '{2'd3, 8'hFF,  32'sd32767},   // R5
      '{2'd3, 8'h00, -32'sd32768},   // R5 full scale down
      '{2'd0, 8'h55,  32'sd0},       // R1 p=1/2
      '{2'd1, 8'h7F,  32'sd24576},   // R1 p=7/8
      '{2'd2, 8'h01, -32'sd24576},   // R1 p=1/8
      '{2'd2, 8'h3F,  32'sd16384},   // R9 p=6/8
      '{2'd1, 8'h07, -32'sd8192}     // R9 p=3/8
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               mod_en = 1'b0;
   logic               mod_bit = 1'b0;
   logic [1:0]         rate_sel = 2'd0;
   logic signed [15:0] pcm_out;
   logic               pcm_valid;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;
   bit  width_bad;
   bit  idle_bad;

   always #10 clk = ~clk;

   sinc3_decim u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .mod_en    (mod_en),
      .mod_bit   (mod_bit),
      .rate_sel  (rate_sel),
      .pcm_out   (pcm_out),
      .pcm_valid (pcm_valid)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One accepted enable followed by two idle cycles with the bit inverted
   task automatic en_step(input logic b, output logic v, output logic signed [15:0] s);
      logic signed [15:0] held;
      @(negedge clk);
      mod_bit = b;
      mod_en  = 1'b1;
      @(negedge clk);
      mod_en  = 1'b0;
      mod_bit = ~b;
      v = pcm_valid;
      s = pcm_out;
      held = pcm_out;
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         if (pcm_valid) width_bad = 1'b1;
         if (pcm_out != held) idle_bad = 1'b1;
      end
   endtask

   // Run one pattern; report enable index of first strobe and check samples
   task automatic run_pattern(input logic [1:0] rate, input logic [7:0] pat,
                              input int exp, input int n_groups);
      int m;
      int first_idx;
      int prev_idx;
      logic v;
      logic signed [15:0] s;
      m = 32 << rate;
      first_idx = -1;
      prev_idx  = -1;
      width_bad = 1'b0;
      idle_bad  = 1'b0;
      for (int k = 1; k <= n_groups * m; k++) begin
         en_step(pat[(k-1) % 8], v, s);
         if (v) begin
            if (first_idx < 0) begin
               first_idx = k;
               // R4 R7 refill after clear takes three output periods
               check(k == 3 * m, "R4", k, 3 * m);
            end else begin
               // R2 R3 strobe spacing equals the selected ratio
               check(k - prev_idx == m, "R2", k - prev_idx, m);
            end
            prev_idx = k;
            // R1 R5 R9 steady level
            check(int'(s) == exp, "R1", int'(s), exp);
         end
      end
      check(first_idx == 3 * m, "R7", first_idx, 3 * m);
      // R3 one-cycle strobe
      check(!width_bad, "R3", int'(width_bad), 0);
      // R6 no change while enable is low
      check(!idle_bad, "R6", int'(idle_bad), 0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic v;
      logic signed [15:0] s;
      repeat (3) @(negedge clk);
      // R8 reset state
      check(pcm_valid == 1'b0, "R8", int'(pcm_valid), 0);
      check(pcm_out == 16'sd0, "R8", int'(pcm_out), 0);
      rst_n = 1'b1;
      @(negedge clk);

      foreach (VECS[i]) begin
         // force a clear by passing through another code
         rate_sel = VECS[i].rate ^ 2'd1;
         @(negedge clk);
         for (int j = 0; j < 10; j++) en_step(1'b1, v, s);
         rate_sel = VECS[i].rate;
         @(negedge clk);
         run_pattern(VECS[i].rate, VECS[i].pat, int'(VECS[i].exp), 5);
      end

      // R8 reset in the middle of a run at code 0
      rate_sel = 2'd1;
      @(negedge clk);
      for (int j = 0; j < 70; j++) en_step(1'b1, v, s);
      rate_sel = 2'd0;
      @(negedge clk);
      for (int j = 0; j < 40; j++) en_step(1'b0, v, s);
      rst_n = 1'b0;
      @(negedge clk);
      check(pcm_out == 16'sd0, "R8", int'(pcm_out), 0);
      check(pcm_valid == 1'b0, "R8", int'(pcm_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_pattern(2'd0, 8'h7F, 24576, 4);

      // R7 enable coinciding with a code change is dropped
      rate_sel = 2'd1;
      @(negedge clk);
      mod_bit = 1'b0;
      mod_en  = 1'b1;
      rate_sel = 2'd0;
      @(negedge clk);
      mod_en = 1'b0;
      rate_sel = 2'd0;
      run_pattern(2'd0, 8'hFF, 32767, 4);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule